// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter with Completion Flag

This block sends asynchronous serial frames on one output line. Software writes a byte into a one-entry holding buffer. The shift stage moves that byte into its own register as soon as it has nothing to send, and the buffer then reports empty again. Software can therefore queue the next byte while the current frame is still on the wire, and consecutive frames follow each other with no idle bit between them. The frame length, the parity mode and the stop count are taken from the configuration inputs at the moment a byte enters the shift stage. The configuration inputs may change freely while a frame is being sent.

A completion flag rises when the last stop bit has finished and no further byte is waiting. This suits half-duplex bus drivers, which must turn their line driver around as soon as the final bit is out. The flag has its own interrupt enable and is gated by a global interrupt enable. It clears itself when its interrupt is acknowledged, and software can also clear it by writing a one. Clearing the transmit enable is deferred: the output enable of the line stays asserted until the shift stage and the buffer have both sent their contents. Only then is the line released.

Baud-rate generation is outside the block. One bit period lasts from one `baud_tick` pulse to the next.

Top module: `uart_tx_dbuf`

The shift stage is a state machine with six states:
- `ST_IDLE`: the line is high and nothing is being sent.
- `ST_START`: the start bit is on the line.
- `ST_DATA`: the data bits are on the line.
- `ST_PARITY`: the parity bit is on the line.
- `ST_STOP1`: the first stop bit is on the line.
- `ST_STOP2`: the second stop bit is on the line.

Each transition other than the load fires on a `baud_tick`:
- `ST_IDLE`→`ST_START` when the buffer is full. This is the load, and it needs no tick.
- `ST_START`→`ST_DATA`.
- `ST_DATA`→`ST_PARITY` after the last data bit, when parity is enabled.
- `ST_DATA`→`ST_STOP1` after the last data bit, when parity is disabled.
- `ST_PARITY`→`ST_STOP1`.
- `ST_STOP1`→`ST_STOP2` when two stop bits are selected.
- `ST_STOP1`→`ST_START` or `ST_STOP2`→`ST_START` at the end of the frame when the buffer is full. This is a direct reload.
- `ST_STOP1`→`ST_IDLE` or `ST_STOP2`→`ST_IDLE` at the end of the frame when the buffer is empty.

## Requirements
- R1: After reset, `txd` is 1, `txd_oe` is 0, `buf_empty` is 1, `txc_flag` is 0 and `txc_irq` is 0.
- R2: A frame consists of a low start bit, then 5+`cfg_bits` data bits sent LSB first, then the stop bits, which are high. The line idles high. Each bit lasts exactly one `baud_tick` period. The first `txd` change appears one clock after the load. The frame settings are sampled at the load.
- R3: When `cfg_parity[1]` is 1, a parity bit follows the last data bit and comes before the first stop bit. The parity bit is the XOR of the sent data bits, inverted when `cfg_parity[0]` is 1 (odd parity). When `cfg_parity[0]` is 0 the parity is even. When `cfg_parity[1]` is 0 no parity bit is sent.
- R4: When `cfg_stop2` is 1 the frame ends with two stop bits. When it is 0 the frame ends with one stop bit.
- R5: An accepted write makes `buf_empty` 0 one clock later. The byte moves into the shift stage when that stage is idle, or on the tick that ends the current frame, and `buf_empty` returns to 1 one clock after that move. A byte waiting at the end of a frame has its start bit directly after the previous stop bit.
- R6: A write while `buf_empty` is 0, or while `cfg_en` is 0, is ignored. The buffer contents and the frame being sent are unchanged.
- R7: `txc_flag` is set one clock after the tick that ends a frame, provided the buffer held no byte at that moment. It is not set when a byte was waiting.
- R8: An asserted `txc_ack` or `txc_clr` clears `txc_flag` on the next clock. If a set happens in the same cycle, the set wins. A data write never clears the flag.
- R9: `txc_irq` is 1 exactly when `txc_flag`, `txc_ie` and `gie` are all 1.
- R10: `txd_oe` becomes 1 one clock after `cfg_en` is 1. After `cfg_en` goes to 0, `txd_oe` stays 1 until the buffer is empty and the shift stage is idle. It falls one clock after that condition is first seen. While `txd_oe` is 0, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse that marks each bit period |
| cfg_en | input | 1 | Transmit enable level |
| cfg_bits | input | 2 | Data length code; the frame carries 5 + code data bits |
| cfg_parity | input | 2 | Bit 1 enables parity; bit 0 selects odd parity |
| cfg_stop2 | input | 1 | Selects two stop bits |
| wr_data | input | 1 | Write strobe for the holding buffer |
| wr_byte | input | 8 | Byte to be written |
| txc_clr | input | 1 | Writes a one to the completion flag, which clears it |
| txc_ack | input | 1 | Acknowledges the completion interrupt |
| txc_ie | input | 1 | Completion interrupt enable |
| gie | input | 1 | Global interrupt enable |
| txd | output | 1 | Serial data line |
| txd_oe | output | 1 | Line driver enable |
| buf_empty | output | 1 | The holding buffer can take a byte |
| txc_flag | output | 1 | Transmit-complete flag |
| txc_irq | output | 1 | Transmit-complete interrupt request |

## Verification
Two functions can land in the same cycle, and the bench provokes both.

The first pair is setting and clearing the completion flag. The bench holds `txc_clr` high across a whole frame, so the frame-ending tick coincides with a clear request. It then expects the flag to read 1 for one clock and 0 on the next.

The second pair is the end of a frame and the load of a queued byte. The bench writes a second byte while the first frame is still being sent. The behavioural bit-queue model expects the next start bit in the clock directly after the last stop bit, and it expects no completion flag at that boundary.

Both cases are judged by comparing every output against the model on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;
endpackage

// File: rtl/tx_holdbuf.sv
module tx_holdbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic [DW-1:0] wr_byte,
    input  logic          cfg_en,
    input  logic          load,
    output logic          buf_full,
    output logic [DW-1:0] buf_byte
);
    logic accept;

    // A write is taken only into an empty buffer, and only while enabled.
    assign accept = wr_data && cfg_en && !buf_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_byte <= '0;
        end else if (accept) begin
            buf_full <= 1'b1;
            buf_byte <= wr_byte;
        end else if (load) begin
            buf_full <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             buf_full,
    input  logic [DW-1:0]    buf_byte,
    input  logic [LEN_W-1:0] cfg_bits,
    input  logic [1:0]       cfg_parity,
    input  logic             cfg_stop2,
    output logic             load,
    output logic             frame_done,
    output logic             busy,
    output logic             txd
);
    localparam int CNT_W    = $clog2(DW);
    localparam int MIN_BITS = DW - (1 << LEN_W) + 1;

    tx_state_e         state, state_n;
    logic [DW-1:0]     sh;
    logic [CNT_W-1:0]  cnt, last_q, last_n;
    logic              par_on_q, par_q, par_n, stop2_q;

    assign frame_done = baud_tick &&
                        ((state == ST_STOP1 && !stop2_q) || state == ST_STOP2);
    assign load       = buf_full && (state == ST_IDLE || frame_done);
    assign busy       = (state != ST_IDLE);
    assign last_n     = CNT_W'(MIN_BITS - 1) + CNT_W'(cfg_bits);

    // Parity over the data bits actually sent, inverted for odd mode.
    always_comb begin
        par_n = cfg_parity[0];
        for (int i = 0; i < DW; i++) begin
            if (CNT_W'(i) <= last_n) par_n = par_n ^ buf_byte[i];
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (buf_full) state_n = ST_START;
            ST_START:  if (baud_tick) state_n = ST_DATA;
            ST_DATA:   if (baud_tick && cnt == last_q)
                           state_n = par_on_q ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (baud_tick) state_n = ST_STOP1;
            ST_STOP1:  if (baud_tick)
                           state_n = stop2_q ? ST_STOP2 :
                                     (buf_full ? ST_START : ST_IDLE);
            ST_STOP2:  if (baud_tick)
                           state_n = buf_full ? ST_START : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            cnt      <= '0;
            last_q   <= '0;
            par_on_q <= 1'b0;
            par_q    <= 1'b0;
            stop2_q  <= 1'b0;
        end else if (load) begin
            sh       <= buf_byte;
            cnt      <= '0;
            last_q   <= last_n;
            par_on_q <= cfg_parity[1];
            par_q    <= par_n;
            stop2_q  <= cfg_stop2;
        end else if (baud_tick && state == ST_DATA) begin
            sh  <= sh >> 1;
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = sh[0];
            ST_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/tx_txcflag.sv
module tx_txcflag (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic buf_full,
    input  logic txc_clr,
    input  logic txc_ack,
    input  logic txc_ie,
    input  logic gie,
    output logic txc_flag,
    output logic txc_irq
);
    logic set_evt;

    assign set_evt = frame_done && !buf_full;

    // A set in the same cycle as a clear takes priority.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  txc_flag <= 1'b0;
        else if (set_evt)            txc_flag <= 1'b1;
        else if (txc_clr || txc_ack) txc_flag <= 1'b0;
    end

    assign txc_irq = txc_flag && txc_ie && gie;
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DW    = 8,
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             cfg_en,
    input  logic [LEN_W-1:0] cfg_bits,
    input  logic [1:0]       cfg_parity,
    input  logic             cfg_stop2,
    input  logic             wr_data,
    input  logic [DW-1:0]    wr_byte,
    input  logic             txc_clr,
    input  logic             txc_ack,
    input  logic             txc_ie,
    input  logic             gie,
    output logic             txd,
    output logic             txd_oe,
    output logic             buf_empty,
    output logic             txc_flag,
    output logic             txc_irq
);
    logic          buf_full, load, frame_done, busy, tx_on;
    logic [DW-1:0] buf_byte;

    tx_holdbuf #(.DW(DW)) i_buf (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_byte(wr_byte),
        .cfg_en(cfg_en), .load(load), .buf_full(buf_full), .buf_byte(buf_byte)
    );

    tx_shifter #(.DW(DW), .LEN_W(LEN_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .buf_full(buf_full),
        .buf_byte(buf_byte), .cfg_bits(cfg_bits), .cfg_parity(cfg_parity),
        .cfg_stop2(cfg_stop2), .load(load), .frame_done(frame_done),
        .busy(busy), .txd(txd)
    );

    tx_txcflag i_flag (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .buf_full(buf_full),
        .txc_clr(txc_clr), .txc_ack(txc_ack), .txc_ie(txc_ie), .gie(gie),
        .txc_flag(txc_flag), .txc_irq(txc_irq)
    );

    // Disable is deferred until nothing is queued or in flight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_on <= 1'b0;
        else        tx_on <= cfg_en || (tx_on && (buf_full || busy));
    end

    assign txd_oe    = tx_on;
    assign buf_empty = !buf_full;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_data,
    input logic cfg_en,
    input logic txc_clr,
    input logic txc_ack,
    input logic txd,
    input logic txd_oe,
    input logic buf_empty,
    input logic txc_flag,
    input logic load,
    input logic frame_done
);
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);

    assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty && !load) |=> !buf_empty);

    assert_ignore_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !cfg_en && buf_empty) |=> buf_empty);

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && buf_empty) |=> txc_flag);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((txc_clr || txc_ack) && !frame_done) |=> !txc_flag);

    assert_oe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_oe && !buf_empty) |=> txd_oe);

    assert_release_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_oe |-> txd);
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .cfg_en(cfg_en),
    .txc_clr(txc_clr), .txc_ack(txc_ack), .txd(txd), .txd_oe(txd_oe),
    .buf_empty(buf_empty), .txc_flag(txc_flag), .load(load),
    .frame_done(frame_done)
);

// File: tb/test_uart_tx_dbuf.sv
module test_uart_tx_dbuf;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       cfg_en = 1'b0;
    logic [1:0] cfg_bits = 2'd3;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic       wr_data = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       txc_clr = 1'b0, txc_ack = 1'b0, txc_ie = 1'b0, gie = 1'b0;
    logic       txd, txd_oe, buf_empty, txc_flag, txc_irq;

    int total = 0, bad = 0, tcnt = 0;
    string txd_tag = "R2", buf_tag = "R5", flag_tag = "R7";

    // behavioural model
    int  q[$];
    bit  m_full = 0, m_flag = 0, m_on = 0;
    bit  m_acc, m_busy, m_full0, m_set, m_on_n;
    logic [7:0] m_byte = 0;

    uart_tx_dbuf i_uart_tx_dbuf (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_en(cfg_en),
        .cfg_bits(cfg_bits), .cfg_parity(cfg_parity), .cfg_stop2(cfg_stop2),
        .wr_data(wr_data), .wr_byte(wr_byte), .txc_clr(txc_clr),
        .txc_ack(txc_ack), .txc_ie(txc_ie), .gie(gie), .txd(txd),
        .txd_oe(txd_oe), .buf_empty(buf_empty), .txc_flag(txc_flag),
        .txc_irq(txc_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        baud_tick <= (tcnt == DIV - 1);
        tcnt = (tcnt == DIV - 1) ? 0 : tcnt + 1;
    end

    task automatic build(input logic [7:0] d);
        int n = 5 + int'(cfg_bits);
        bit p = cfg_parity[0];
        q.push_back(0);
        for (int i = 0; i < n; i++) begin
            q.push_back(int'(d[i]));
            p = p ^ d[i];
        end
        if (cfg_parity[1]) q.push_back(int'(p));
        q.push_back(1);
        if (cfg_stop2) q.push_back(1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_full = 0; m_flag = 0; m_on = 0;
        end else begin
            m_acc   = wr_data && cfg_en && !m_full;
            m_busy  = (q.size() != 0);
            m_full0 = m_full;
            m_set   = 0;
            m_on_n  = cfg_en || (m_on && (m_full0 || m_busy));
            if (m_busy && baud_tick) begin
                void'(q.pop_front());
                if (q.size() == 0) begin
                    if (m_full0) begin build(m_byte); m_full = 0; end
                    else m_set = 1;
                end
            end else if (!m_busy && m_full0) begin
                build(m_byte); m_full = 0;
            end
            if (m_acc) begin m_byte = wr_byte; m_full = 1; end
            if (m_set) m_flag = 1;
            else if (txc_clr || txc_ack) m_flag = 0;
            m_on = m_on_n;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(txd_tag, "txd", txd, (q.size() != 0) ? logic'(q[0]) : 1'b1);
            check("R10", "txd_oe", txd_oe, m_on);
            check(buf_tag, "buf_empty", buf_empty, !m_full);
            check(flag_tag, "txc_flag", txc_flag, m_flag);
            check("R9", "txc_irq", txc_irq, m_flag && txc_ie && gie);
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic put(input logic [7:0] b);
        wr_data = 1'b1; wr_byte = b;
        cyc(1);
        wr_data = 1'b0;
    endtask

    task automatic wait_done();
        while (q.size() != 0 || m_full) cyc(1);
        cyc(2);
    endtask

    task automatic wait_empty();
        while (m_full) cyc(1);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        @(negedge clk);
        check("R1", "txd", txd, 1'b1);
        check("R1", "txd_oe", txd_oe, 1'b0);
        check("R1", "buf_empty", buf_empty, 1'b1);
        check("R1", "txc_flag", txc_flag, 1'b0);
        check("R1", "txc_irq", txc_irq, 1'b0);
        rst_n = 1'b1;
        cyc(2);

        // R2: 8 data bits, no parity, one stop bit; R7 flag at end
        cfg_en = 1'b1; cyc(1);
        put(8'hA5);
        wait_done();
        @(negedge clk); check("R7", "txc_flag after frame", txc_flag, 1'b1);
        cyc(1);

        // R9: interrupt gating
        txc_ie = 1'b1; gie = 1'b0; cyc(1);
        @(negedge clk); check("R9", "irq with gie low", txc_irq, 1'b0);
        gie = 1'b1; cyc(1);
        @(negedge clk); check("R9", "irq all enabled", txc_irq, 1'b1);
        txc_ack = 1'b1; cyc(1); txc_ack = 1'b0; flag_tag = "R8";
        @(negedge clk); check("R8", "flag after ack", txc_flag, 1'b0);
        cyc(1);

        // R3: even and odd parity with 7 data bits, back-to-back (R5)
        txd_tag = "R3"; flag_tag = "R7";
        cfg_bits = 2'd2; cfg_parity = 2'b10;
        put(8'h35);
        wait_empty();
        put(8'h4B);
        wait_empty();
        cfg_parity = 2'b11;
        put(8'h0F);
        wait_done();
        txc_clr = 1'b1; cyc(1); txc_clr = 1'b0;

        // R4: two stop bits, 5 data bits, odd parity
        txd_tag = "R4";
        cfg_bits = 2'd0; cfg_stop2 = 1'b1; cfg_parity = 2'b11;
        put(8'h16);
        wait_empty();
        put(8'h09);
        wait_done();
        cfg_stop2 = 1'b0; cfg_parity = 2'b00;
        txc_clr = 1'b1; cyc(1); txc_clr = 1'b0;

        // R6: writes ignored while full and while disabled
        txd_tag = "R2"; buf_tag = "R6";
        cfg_bits = 2'd3;
        put(8'h81);
        wait_empty();
        put(8'h42);
        put(8'hFF);
        put(8'h00);
        wait_done();
        cfg_en = 1'b0; cyc(3);
        put(8'h5A);
        cyc(2);
        @(negedge clk); check("R6", "buf_empty after disabled write", buf_empty, 1'b1);
        check("R6", "txd idle after disabled write", txd, 1'b1);
        buf_tag = "R5";

        // R10: deferred disable with two bytes queued
        cfg_en = 1'b1; cyc(2);
        put(8'hC3);
        wait_empty();
        put(8'h3C);
        cfg_en = 1'b0;
        cyc(4);
        @(negedge clk); check("R10", "oe held while queued", txd_oe, 1'b1);
        wait_done();
        @(negedge clk); check("R10", "oe released", txd_oe, 1'b0);
        txc_clr = 1'b1; cyc(1); txc_clr = 1'b0;

        // R8: clear held across frame end; set wins, then clears
        flag_tag = "R8";
        cfg_en = 1'b1; cyc(1);
        txc_clr = 1'b1;
        put(8'h99);
        wait_done();
        txc_clr = 1'b0;
        put(8'h66);
        wait_done();
        put(8'h12);
        cyc(3);
        @(negedge clk); check("R8", "flag kept over data write", txc_flag, 1'b1);
        wait_done();

        summary();
        $finish;
    end
endmodule